// File: doc/BRIEF.md
# Stride-Based Zero-Padding Symbol Spreader

This block sits at the front of a non-orthogonal multicarrier transmitter. It collects a frame of N complex symbols and then streams out an expanded frame of c·N samples. Symbol n lands at output index n·b and every other index carries zero. The ratio b/c sets how tightly the sub-carriers are packed downstream. b = c gives ordinary orthogonal spacing, and b < c gives compressed spacing. Both cases run on the same hardware without reconfiguration.

The stride b, the expansion factor c and log2(N) are run-time inputs. The block samples them once per frame, when the first symbol of the frame is accepted. It uses no divider to decide where symbols land. An output position counter is compared with an accumulator that starts at zero and grows by b each time a symbol is placed. A source counter selects the next stored symbol.

The block works in two phases. In the load phase it stores N symbols, and in_valid may have gaps. In the emit phase it outputs one sample per clock with no gaps. The inverse transforms and the phase rotation that follow the block are outside its scope.

Top module: `stride_spreader`

## Requirements
- R1: Each output frame has exactly c·N samples. out_last is high only on the sample at index c·N−1.
- R2: Output sample j equals S_q when j mod b = 0 and q = j / b < N. Otherwise it is zero (both parts 0). The result is identical to the divide-and-remainder method, and it holds for b = c as well as for b < c.
- R3: N = 2^cfg_log2n. A cfg_log2n below 2 is treated as 2, and one above MAX_LOG2N is treated as MAX_LOG2N. Each real and imaginary part is DW = 16 bits wide.
- R4: Once a frame starts to emit, out_valid is high on every clock until out_last. In the cycle after out_last, out_valid is low.
- R5: Symbols are accepted only in the load phase, and gaps in in_valid during loading are allowed. Any in_valid during the emit phase is ignored and does not appear in the next frame.
- R6: cfg_stride, cfg_expand and cfg_log2n are sampled together with the first symbol of a frame. A change after that point takes effect on the next frame only.
- R7: A cfg_stride of 0 is treated as 1, and a cfg_expand of 0 is treated as 1.
- R8: When b·(N−1) ≥ c·N, placements that would fall at or past c·N are dropped. err_range goes high at the end of that frame and stays high until reset.
- R9: While and after reset, out_valid, out_last and err_range are low and the data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stride | input | BW | Placement stride b |
| cfg_expand | input | CW | Expansion factor c |
| cfg_log2n | input | LW | log2 of the frame length N |
| in_valid | input | 1 | Input symbol strobe |
| in_re | input | DW | Input symbol, real part |
| in_im | input | DW | Input symbol, imaginary part |
| out_valid | output | 1 | Output sample strobe |
| out_re | output | DW | Output sample, real part |
| out_im | output | DW | Output sample, imaginary part |
| out_last | output | 1 | Marks the final sample of a frame |
| err_range | output | 1 | Sticky flag for dropped placements |

## Verification
Each frame's output is compared sample by sample with a model that divides the index by b and tests the remainder. Frames are run with:
- b = 2, c = 2, to cover interleaved zeros;
- b = c = 3, the orthogonal case;
- b = 2, c = 3 with N = 16, the compressed case;
- b = c = 1, the pass-through case.

These runs separate errors in the accumulator step from errors in the length and last-flag logic. Gapped input, b changed in the middle of a load, and junk strobes during emission show whether the configuration and the stored symbols stay fixed for the whole frame. Zero and out-of-range configuration codes, and a stride large enough to overflow the frame, exercise the clamping rules and the sticky error flag.

// File: rtl/stride_spreader.sv
module stride_spreader #(
  parameter int DW        = 16,
  parameter int MAX_LOG2N = 4,
  parameter int BW        = 4,
  parameter int CW        = 4,
  parameter int LW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] cfg_stride,
  input  logic [CW-1:0] cfg_expand,
  input  logic [LW-1:0] cfg_log2n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  output logic          out_valid,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im,
  output logic          out_last,
  output logic          err_range
);
  localparam int NMAX = 1 << MAX_LOG2N;
  localparam int NW   = MAX_LOG2N + 1;
  localparam int TW   = MAX_LOG2N + CW;
  localparam int AW   = BW + MAX_LOG2N + 1;

  logic [2*DW-1:0] store [NMAX];

  logic            emitting;
  logic [BW-1:0]   b_q;
  logic [CW-1:0]   c_q;
  logic [NW-1:0]   n_q;
  logic [MAX_LOG2N-1:0] wr_cnt;
  logic [TW-1:0]   pos;
  logic [NW-1:0]   src;
  logic [AW-1:0]   slot;

  logic [BW-1:0]   b_in;
  logic [CW-1:0]   c_in;
  logic [LW-1:0]   l_in;
  logic [NW-1:0]   n_in, n_cur, src_nx;
  logic [TW-1:0]   total;
  logic            take, start, last_load, hit, last_out;

  assign b_in  = (cfg_stride == '0) ? BW'(1) : cfg_stride;
  assign c_in  = (cfg_expand == '0) ? CW'(1) : cfg_expand;
  assign l_in  = (cfg_log2n < LW'(2)) ? LW'(2) :
                 (cfg_log2n > LW'(MAX_LOG2N)) ? LW'(MAX_LOG2N) : cfg_log2n;
  assign n_in  = NW'(1) << l_in;

  assign take      = !emitting && in_valid;
  assign start     = take && (wr_cnt == '0);
  assign n_cur     = start ? n_in : n_q;
  assign last_load = take && ({1'b0, wr_cnt} == n_cur - NW'(1));

  assign total    = TW'(c_q) * TW'(n_q);
  assign hit      = emitting && (src < n_q) && (AW'(pos) == slot);
  assign last_out = emitting && (pos == total - TW'(1));
  assign src_nx   = src + NW'(hit);

  always_ff @(posedge clk) begin
    if (take) store[wr_cnt] <= {in_re, in_im};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emitting  <= 1'b0;
      b_q       <= BW'(1);
      c_q       <= CW'(1);
      n_q       <= NW'(4);
      wr_cnt    <= '0;
      pos       <= '0;
      src       <= '0;
      slot      <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      err_range <= 1'b0;
    end else begin
      out_valid <= emitting;
      out_last  <= last_out;
      {out_re, out_im} <= hit ? store[src[MAX_LOG2N-1:0]] : '0;

      if (start) begin
        b_q <= b_in;
        c_q <= c_in;
        n_q <= n_in;
      end

      if (take) begin
        wr_cnt <= last_load ? '0 : wr_cnt + 1'b1;
        if (last_load) begin
          emitting <= 1'b1;
          pos      <= '0;
          src      <= '0;
          slot     <= '0;
        end
      end

      if (emitting) begin
        pos <= pos + 1'b1;
        src <= src_nx;
        if (hit) slot <= slot + AW'(b_q);
        if (last_out) begin
          emitting <= 1'b0;
          if (src_nx < n_q) err_range <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stride_spreader_chk.sv
module stride_spreader_chk #(
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_last,
  input logic          err_range,
  input logic          emitting,
  input logic [BW-1:0] b_q
);
  assert_last_with_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_gapless_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid);

  assert_gap_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_range |=> err_range);

  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    emitting && out_valid |-> $stable(b_q));
endmodule

bind stride_spreader stride_spreader_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_last(out_last),
  .err_range(err_range), .emitting(emitting), .b_q(b_q)
);

// File: tb/stride_spreader_bench.sv
module stride_spreader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_stride = 4'd1;
  logic [3:0]  cfg_expand = 4'd1;
  logic [2:0]  cfg_log2n  = 3'd2;
  logic        in_valid = 1'b0;
  logic [15:0] in_re = '0, in_im = '0;
  logic        out_valid, out_last, err_range;
  logic [15:0] out_re, out_im;

  stride_spreader u_stride_spreader (
    .clk(clk), .rst_n(rst_n), .cfg_stride(cfg_stride), .cfg_expand(cfg_expand),
    .cfg_log2n(cfg_log2n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
    .out_last(out_last), .err_range(err_range)
  );

  always #10 clk = ~clk;

  integer checks = 0, fails = 0;
  logic [31:0] cap [0:511];
  integer cap_n = 0, last_idx = -1;
  bit got_last = 0;

  always @(negedge clk) begin
    if (out_valid) begin
      cap[cap_n] = {out_re, out_im};
      if (out_last) begin
        last_idx = cap_n;
        got_last = 1;
      end
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sym(input int tag, input int n);
    logic [15:0] r;
    r = {tag[7:0], n[7:0]};
    return {r, ~r};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!out_valid && !out_last && !err_range && out_re == 0 && out_im == 0, "R9 reset",
        {out_valid, out_last, err_range}, 0);
    rst_n = 1'b1;
  endtask

  task automatic send_frame(input int b, input int c, input int l, input int tag,
                            input bit gap, input bit change, input bit junk);
    int n;
    int nn;
    nn = 1 << ((l < 2) ? 2 : (l > 4) ? 4 : l);
    @(posedge clk); #1;
    cfg_stride = b[3:0]; cfg_expand = c[3:0]; cfg_log2n = l[2:0];
    cap_n = 0; last_idx = -1; got_last = 0;
    for (n = 0; n < nn; n++) begin
      in_valid = 1'b1;
      {in_re, in_im} = sym(tag, n);
      @(posedge clk); #1;
      if (change) begin
        cfg_stride = 4'd7; cfg_expand = 4'd9; cfg_log2n = 3'd3;
      end
      if (gap) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0;
    if (junk) begin
      while (!out_valid) begin @(posedge clk); #1; end
      repeat (3) begin
        in_valid = 1'b1;
        {in_re, in_im} = 32'hDEADBEEF;
        @(posedge clk); #1;
      end
      in_valid = 1'b0;
    end
    while (!got_last) begin @(posedge clk); #1; end
    @(posedge clk); #1;
  endtask

  task automatic expect_frame(input int b, input int c, input int l, input int tag, input string req);
    int bb, cc, nn, tot;
    logic [31:0] e;
    bb = (b == 0) ? 1 : b;
    cc = (c == 0) ? 1 : c;
    nn = 1 << ((l < 2) ? 2 : (l > 4) ? 4 : l);
    tot = cc * nn;
    chk(cap_n == tot, {req, " R1 length"}, cap_n, tot);
    chk(last_idx == tot - 1, {req, " R1 last index"}, last_idx, tot - 1);
    for (int j = 0; j < tot; j++) begin
      e = ((j % bb) == 0 && (j / bb) < nn) ? sym(tag, j / bb) : 32'h0;
      chk(cap[j] == e, {req, " R2 sample"}, cap[j], e);
    end
  endtask

  task automatic t_stride2();
    send_frame(2, 2, 2, 1, 0, 0, 0);
    expect_frame(2, 2, 2, 1, "stride2");
  endtask

  task automatic t_orthogonal();
    send_frame(3, 3, 3, 2, 0, 0, 0);
    expect_frame(3, 3, 3, 2, "orthogonal");
  endtask

  task automatic t_compressed();
    send_frame(2, 3, 4, 3, 0, 0, 0);
    expect_frame(2, 3, 4, 3, "compressed");
  endtask

  task automatic t_unity_gapped();
    send_frame(1, 1, 3, 4, 1, 0, 0);
    expect_frame(1, 1, 3, 4, "R5 gapped input");
  endtask

  task automatic t_cfg_change();
    send_frame(2, 3, 2, 5, 0, 1, 0);
    expect_frame(2, 3, 2, 5, "R6 mid-load change");
    send_frame(7, 9, 3, 6, 0, 0, 0);
    expect_frame(7, 9, 3, 6, "R6 next frame");
  endtask

  task automatic t_ignore_during_emit();
    send_frame(2, 4, 2, 7, 0, 0, 1);
    expect_frame(2, 4, 2, 7, "R5 junk frame");
    send_frame(3, 4, 2, 8, 0, 0, 0);
    expect_frame(3, 4, 2, 8, "R5 after junk");
  endtask

  task automatic t_zero_and_clamp();
    send_frame(0, 0, 0, 9, 0, 0, 0);
    expect_frame(0, 0, 0, 9, "R7 R3 zero codes");
    send_frame(1, 2, 7, 10, 0, 0, 0);
    expect_frame(1, 2, 7, 10, "R3 clamp high");
    chk(err_range == 1'b0, "R8 no error on legal frames", err_range, 0);
  endtask

  task automatic t_overflow();
    send_frame(5, 1, 2, 11, 0, 0, 0);
    expect_frame(5, 1, 2, 11, "R8 overflow");
    chk(err_range == 1'b1, "R8 error raised", err_range, 1);
    send_frame(1, 1, 2, 12, 0, 0, 0);
    expect_frame(1, 1, 2, 12, "R8 good after overflow");
    chk(err_range == 1'b1, "R8 error sticky", err_range, 1);
    do_reset();
    chk(err_range == 1'b0, "R8 R9 cleared by reset", err_range, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_stride2();
    t_orthogonal();
    t_compressed();
    t_unity_gapped();
    t_cfg_change();
    t_ignore_during_emit();
    t_zero_and_clamp();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule